// File: doc/BRIEF.md
# Lane Alignment Character Inserter

This block sits on one transmit lane of a JESD204B link, between the scrambler and the 8b/10b encoder. It counts octets into frames and frames into multiframes. At those boundaries it swaps selected data octets for the frame-alignment control character (K28.7) or the multiframe-alignment control character (K28.3). A receiver uses these characters to watch the health of the link's alignment. Every octet leaves with a control flag, so the encoder can tell K characters from data.

The frame length F (1 to 16 octets) and the multiframe length K (1 to 32 frames) are set with minus-one encoded inputs. A start-of-data strobe that comes with an accepted octet marks that octet as the first octet of frame 0 of a multiframe. A mode input picks the substitution rule. With scrambling off, a frame-end octet is compared with the stored last octet of the previous frame. With scrambling on, it is compared with fixed values. The block passes octets through a valid/ready interface with one registered stage.

Top module: `lane_align_inserter`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: An octet accepted at a clock edge (in_valid_i and in_ready_o both 1) appears on the outputs with out_valid_o=1 after that same edge. in_ready_o is 1 whenever out_ready_i is 1, so back-to-back octets flow at one per cycle.
- R3: While out_valid_o=1 and out_ready_i=0, in_ready_o is 0 and out_data_o and out_ctrl_o hold their values.
- R4: Frame length is frame_len_m1_i+1 and multiframe length is mf_len_m1_i+1 frames. An accepted octet with sod_i=1 is octet 0 of frame 0. Octets that are not at a frame end pass unchanged with out_ctrl_o=0.
- R5: With scr_en_i=0, a frame-end octet that equals the stored previous frame-end octet, in a frame that is not the last of its multiframe, is output as 0xFC with out_ctrl_o=1 (K28.7).
- R6: With scr_en_i=0, such a matching octet in the last frame of a multiframe is output as 0x7C with out_ctrl_o=1 (K28.3).
- R7: The stored previous frame-end octet is the original input value, not the substituted code. After reset no octet is stored, so the first frame end is never substituted.
- R8: With scr_en_i=1, a frame-end octet equal to 0xFC is output as 0xFC with out_ctrl_o=1. This holds at multiframe ends too.
- R9: With scr_en_i=1, a multiframe-end octet equal to 0x7C is output as 0x7C with out_ctrl_o=1. A 0x7C at a frame end that is not a multiframe end passes as data with out_ctrl_o=0.
- R10: out_ctrl_o=1 only at frame ends and only with the codes 0xFC or 0x7C. 0x7C only appears as a control code at multiframe ends.
- R11: With scr_en_i=1, matching the previous frame-end octet has no effect: a repeated frame-end value other than 0xFC/0x7C passes as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scr_en_i | input | 1 | 1 selects scrambled substitution rules |
| frame_len_m1_i | input | 4 | Octets per frame minus one |
| mf_len_m1_i | input | 5 | Frames per multiframe minus one |
| sod_i | input | 1 | Marks the accepted octet as first of a multiframe |
| in_valid_i | input | 1 | Input octet valid |
| in_ready_o | output | 1 | Block can accept an octet |
| in_data_i | input | 8 | Input octet |
| out_valid_o | output | 1 | Output octet valid |
| out_ready_i | input | 1 | Encoder accepts the output octet |
| out_data_o | output | 8 | Output octet or control code |
| out_ctrl_o | output | 1 | 1 when out_data_o is a K character |

## Verification
The bench checks a single-octet frame with a single-frame multiframe. There every octet is both a frame end and a multiframe end, so a design that mixed up the two counters would send K28.7 where K28.3 belongs. It repeats one frame-end value three times in unscrambled mode. A design that stored the substituted code would stop matching on the third frame. It also sends 0x7C and 0xFC mid-frame and at plain frame ends in scrambled mode, and repeats ordinary values there. This catches rules that fire at the wrong position or leak across modes. A stall with new input waiting catches an output register that gets overwritten or that drops octets. A mid-stream start-of-data strobe catches counters that fail to realign.

// File: rtl/lai_pkg.sv
package lai_pkg;
  localparam int unsigned OCT_W = 8;
  localparam logic [OCT_W-1:0] K_FRAME = 8'hFC; // K28.7
  localparam logic [OCT_W-1:0] K_MULTI = 8'h7C; // K28.3

  typedef struct packed {
    logic [OCT_W-1:0] data;
    logic             ctrl;
    logic             fend;
    logic             mfend;
  } lai_beat_t;
endpackage

// File: rtl/lai_pos_tracker.sv
module lai_pos_tracker #(
  parameter int unsigned FLEN_W = 4,
  parameter int unsigned MLEN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              sod_i,
  input  logic [FLEN_W-1:0] flen_m1_i,
  input  logic [MLEN_W-1:0] mlen_m1_i,
  output logic              fend_o,
  output logic              mfend_o
);
  logic [FLEN_W-1:0] oct_q, oct_cur;
  logic [MLEN_W-1:0] frm_q, frm_cur;

  // strobe forces this octet to position 0/0
  assign oct_cur = sod_i ? '0 : oct_q;
  assign frm_cur = sod_i ? '0 : frm_q;
  // >= keeps counters bounded if lengths shrink on the fly
  assign fend_o  = (oct_cur >= flen_m1_i);
  assign mfend_o = fend_o && (frm_cur >= mlen_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_q <= '0;
      frm_q <= '0;
    end else if (adv_i) begin
      if (fend_o) begin
        oct_q <= '0;
        frm_q <= mfend_o ? '0 : frm_cur + 1'b1;
      end else begin
        oct_q <= oct_cur + 1'b1;
        frm_q <= frm_cur;
      end
    end
  end
endmodule

// File: rtl/lai_prev_store.sv
module lai_prev_store
  import lai_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OCT_W-1:0] data_i,
  output logic [OCT_W-1:0] prev_o,
  output logic             prev_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o     <= '0;
      prev_vld_o <= 1'b0;
    end else if (wr_i) begin
      prev_o     <= data_i; // raw input, never the K code
      prev_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lai_sub_decider.sv
module lai_sub_decider
  import lai_pkg::*;
(
  input  logic             scr_en_i,
  input  logic [OCT_W-1:0] data_i,
  input  logic             fend_i,
  input  logic             mfend_i,
  input  logic [OCT_W-1:0] prev_i,
  input  logic             prev_vld_i,
  output lai_beat_t        beat_o
);
  logic match_prev, use_f, use_a;

  assign match_prev = prev_vld_i && (data_i == prev_i);

  always_comb begin
    use_f = 1'b0;
    use_a = 1'b0;
    if (fend_i) begin
      if (scr_en_i) begin
        use_a = mfend_i && (data_i == K_MULTI);
        use_f = (data_i == K_FRAME);
      end else if (match_prev) begin
        use_a = mfend_i;
        use_f = !mfend_i;
      end
    end
  end

  always_comb begin
    beat_o.fend  = fend_i;
    beat_o.mfend = mfend_i;
    beat_o.ctrl  = use_f || use_a;
    beat_o.data  = use_a ? K_MULTI : (use_f ? K_FRAME : data_i);
  end
endmodule

// File: rtl/lai_out_stage.sv
module lai_out_stage
  import lai_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  output logic      in_ready_o,
  input  lai_beat_t beat_i,
  output logic      out_valid_o,
  input  logic      out_ready_i,
  output lai_beat_t beat_o
);
  logic load;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      beat_o      <= '0;
    end else if (load) begin
      out_valid_o <= 1'b1;
      beat_o      <= beat_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_align_inserter.sv
module lane_align_inserter
  import lai_pkg::*;
#(
  parameter int unsigned FLEN_W = 4,
  parameter int unsigned MLEN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scr_en_i,
  input  logic [FLEN_W-1:0] frame_len_m1_i,
  input  logic [MLEN_W-1:0] mf_len_m1_i,
  input  logic              sod_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OCT_W-1:0]  in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OCT_W-1:0]  out_data_o,
  output logic              out_ctrl_o
);
  logic             accept, fend, mfend, prev_vld;
  logic [OCT_W-1:0] prev;
  lai_beat_t        beat_d, beat_q;
  logic             out_fend, out_mfend;

  assign accept = in_valid_i && in_ready_o;

  lai_pos_tracker #(.FLEN_W(FLEN_W), .MLEN_W(MLEN_W)) i_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(accept), .sod_i(sod_i),
    .flen_m1_i(frame_len_m1_i), .mlen_m1_i(mf_len_m1_i),
    .fend_o(fend), .mfend_o(mfend)
  );

  lai_prev_store i_prev (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(accept && fend),
    .data_i(in_data_i), .prev_o(prev), .prev_vld_o(prev_vld)
  );

  lai_sub_decider i_sub (
    .scr_en_i(scr_en_i), .data_i(in_data_i), .fend_i(fend), .mfend_i(mfend),
    .prev_i(prev), .prev_vld_i(prev_vld), .beat_o(beat_d)
  );

  lai_out_stage i_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .beat_i(beat_d), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .beat_o(beat_q)
  );

  assign out_data_o = beat_q.data;
  assign out_ctrl_o = beat_q.ctrl;
  assign out_fend   = beat_q.fend;
  assign out_mfend  = beat_q.mfend;
endmodule

module lai_checker
  import lai_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_i,
  input logic             out_valid_i,
  input logic             out_ready_i,
  input logic [OCT_W-1:0] out_data_i,
  input logic             out_ctrl_i,
  input logic             out_fend_i,
  input logic             out_mfend_i
);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_i |=> out_valid_i);
  p_no_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_i);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_data_i) && $stable(out_ctrl_i));
  p_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |-> !in_ready_i);
  p_ctrl_pos_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && out_ctrl_i |-> out_fend_i && (out_data_i == K_FRAME || out_data_i == K_MULTI));
  p_multi_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && out_ctrl_i && out_data_i == K_MULTI |-> out_mfend_i);
endmodule

bind lane_align_inserter lai_checker i_lai_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_i(in_ready_o),
  .out_valid_i(out_valid_o), .out_ready_i(out_ready_i), .out_data_i(out_data_o),
  .out_ctrl_i(out_ctrl_o), .out_fend_i(out_fend), .out_mfend_i(out_mfend)
);

// File: tb/test_lane_align_inserter.sv
module test_lane_align_inserter;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       scr_en_i;
  logic [3:0] frame_len_m1_i;
  logic [4:0] mf_len_m1_i;
  logic       sod_i, in_valid_i, in_ready_o, out_valid_o, out_ready_i, out_ctrl_o;
  logic [7:0] in_data_i, out_data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  int         m_oct, m_frm;
  logic [7:0] m_prev;
  bit         m_pv;

  always #2 clk_i = ~clk_i;

  lane_align_inserter i_lane_align_inserter (.*);

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] d, input bit sod,
                       output logic [7:0] ed, output bit ec, output string tag);
    int flen = int'(frame_len_m1_i) + 1;
    int mlen = int'(mf_len_m1_i) + 1;
    bit fe, mfe;
    if (sod) begin m_oct = 0; m_frm = 0; end
    fe  = (m_oct == flen - 1);
    mfe = fe && (m_frm == mlen - 1);
    ed = d; ec = 0; tag = fe ? "R10" : "R4";
    if (scr_en_i) begin
      if (mfe && d == 8'h7C) begin ec = 1; tag = "R9"; end
      else if (fe && d == 8'hFC) begin ec = 1; tag = "R8"; end
      else if (fe) tag = "R11";
    end else if (fe && m_pv && d == m_prev) begin
      ec = 1; ed = mfe ? 8'h7C : 8'hFC; tag = mfe ? "R6" : "R5";
    end else if (fe) tag = "R7";
    if (fe) begin
      m_prev = d; m_pv = 1;
      m_oct = 0; m_frm = mfe ? 0 : m_frm + 1;
    end else m_oct++;
  endtask

  task automatic do_reset();
    rst_ni = 0; in_valid_i = 0; sod_i = 0; in_data_i = 0; out_ready_i = 1;
    m_oct = 0; m_frm = 0; m_prev = 0; m_pv = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  // drive at negedge, check at next negedge (one register on the path)
  task automatic push(input logic [7:0] d, input bit sod);
    logic [7:0] ed; bit ec; string tag;
    model(d, sod, ed, ec, tag);
    in_valid_i = 1; in_data_i = d; sod_i = sod;
    @(negedge clk_i);
    check(out_valid_o === 1'b1, "R2", {8'h0, out_valid_o}, 9'h1);
    check(in_ready_o === 1'b1, "R2", {8'h0, in_ready_o}, 9'h1);
    check(out_data_o === ed && out_ctrl_o === ec, tag, {out_ctrl_o, out_data_o}, {ec, ed});
    in_valid_i = 0; sod_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid_o === 1'b0, "R1", {8'h0, out_valid_o}, 9'h0);
    check(in_ready_o === 1'b1, "R1", {8'h0, in_ready_o}, 9'h1);
  endtask

  task automatic t_unscrambled();
    do_reset();
    scr_en_i = 0; frame_len_m1_i = 3; mf_len_m1_i = 3;
    // R7: first frame end not substituted; R5 then; stored value is raw 0x55
    push(8'h10, 1); push(8'h11, 0); push(8'h55, 0); push(8'h55, 0);
    push(8'h55, 0); push(8'h21, 0); push(8'h22, 0); push(8'h55, 0);
    push(8'h30, 0); push(8'h31, 0); push(8'h32, 0); push(8'h55, 0);
    // R6: last frame of multiframe
    push(8'h40, 0); push(8'h41, 0); push(8'h42, 0); push(8'h55, 0);
    // R4: new multiframe, mismatch
    push(8'h50, 0); push(8'h51, 0); push(8'h52, 0); push(8'h66, 0);
  endtask

  task automatic t_scrambled();
    do_reset();
    scr_en_i = 1; frame_len_m1_i = 2; mf_len_m1_i = 1;
    push(8'hFC, 1); push(8'h7C, 0); push(8'h7C, 0);   // R9 7C at plain frame end passes
    push(8'h01, 0); push(8'hFC, 0); push(8'h7C, 0);   // R9 multiframe end
    push(8'h02, 0); push(8'h03, 0); push(8'hFC, 0);   // R8
    push(8'h04, 0); push(8'h05, 0); push(8'hFC, 0);   // R8 at multiframe end
    push(8'h06, 0); push(8'h07, 0); push(8'h99, 0);   // R11
    push(8'h08, 0); push(8'h09, 0); push(8'h99, 0);   // R11 repeated
  endtask

  task automatic t_tiny();
    do_reset();
    scr_en_i = 0; frame_len_m1_i = 0; mf_len_m1_i = 0;
    push(8'hA5, 1); push(8'hA5, 0); push(8'hA5, 0); push(8'h5A, 0); push(8'h5A, 0);
    scr_en_i = 1;
    push(8'hFC, 0); push(8'h7C, 0);
  endtask

  task automatic t_resync();
    do_reset();
    scr_en_i = 1; frame_len_m1_i = 15; mf_len_m1_i = 31;
    for (int i = 0; i < 5; i++) push(8'h7C, i == 0);
    push(8'h01, 1); // R4 realign mid-frame
    for (int i = 0; i < 14; i++) push(8'hFC, 0);
    push(8'hFC, 0);  // frame end after resync -> R8
  endtask

  task automatic t_stall();
    logic [7:0] ed1, ed2; bit ec1, ec2; string tg1, tg2;
    do_reset();
    scr_en_i = 1; frame_len_m1_i = 1; mf_len_m1_i = 0;
    model(8'h33, 1, ed1, ec1, tg1);
    model(8'h7C, 0, ed2, ec2, tg2);
    out_ready_i = 0; in_valid_i = 1; in_data_i = 8'h33; sod_i = 1;
    @(negedge clk_i);
    sod_i = 0; in_data_i = 8'h7C;
    for (int i = 0; i < 3; i++) begin
      check(in_ready_o === 1'b0, "R3", {8'h0, in_ready_o}, 9'h0);
      check(out_valid_o === 1'b1 && out_data_o === ed1 && out_ctrl_o === ec1, "R3",
            {out_ctrl_o, out_data_o}, {ec1, ed1});
      @(negedge clk_i);
    end
    out_ready_i = 1;
    @(negedge clk_i);
    in_valid_i = 0;
    check(out_valid_o === 1'b1 && out_data_o === ed2 && out_ctrl_o === ec2, "R9",
          {out_ctrl_o, out_data_o}, {ec2, ed2});
    @(negedge clk_i);
    check(out_valid_o === 1'b0, "R2", {8'h0, out_valid_o}, 9'h0);
  endtask

  initial begin
    scr_en_i = 0; frame_len_m1_i = 0; mf_len_m1_i = 0;
    t_reset();
    t_unscrambled();
    t_scrambled();
    t_tiny();
    t_resync();
    t_stall();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule